// File: doc/BRIEF.md
# Low Power Mode Sequencer

This block decides which power state a small microcontroller core is in, and it drives the clock, regulator, oscillator and flash power controls for that state. The CPU signals its sleep instructions as one-cycle requests: wait-for-interrupt, wait-for-event, halt, enter low-power-run and leave low-power-run. Interrupts, events, asynchronous wakeup lines and the busy flags of other units then decide when the core sleeps and when it wakes. The regulators, oscillators and the flash are treated as simple enable/ready handshakes.

Six visible states are supported: Run, Wait, Low-power-run, Low-power-wait, Active-halt and Halt. A halt request first passes through a hold stage, where it waits for pending clock switches and memory writes to finish. A woken core remembers where it came from. When the activation-level setting is on, or when it slept in wait-for-event, the return from its interrupt routine sends it straight back to sleep. Leaving low-power-run follows a fixed handshake: regulator first, then flash, then the fast oscillator.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the state is Run (status 0). The CPU, peripheral, main-regulator, fast-oscillator and slow-oscillator enables are 1, flash power-down is 0, and `clk_hsi8` is 1, meaning the system clock is the fast internal oscillator divided by 8.
- R2: In Wait (status 1) only the CPU clock is stopped. `gie_set` is 1 for exactly the first cycle of each Wait entry. `flash_pd` in Wait follows `cfg_wait_fpd`.
- R3: A wait entered by `req_wfi` stays asleep until `irq_pending` is seen, and then returns to Run on the next clock.
- R4: In a wait entered by `req_wfe`, an event returns to Run with no interrupt context. An interrupt alone returns to Run, and the following `isr_return` re-enters Wait. When event and interrupt arrive in the same cycle, the event wins and a later `isr_return` leaves the core in Run.
- R5: A halt request moves the core to a hold stage (status 0, CPU clock off). It stays there while the clock-switch, memory-write or RTC-switch busy flag is set. The beeper busy flag also holds it, but only when `cfg_ahalt` and `cfg_beep_keep` are both 1.
- R6: If `irq_pending` is already set when the hold stage ends, the halt state lasts exactly one cycle, and then the core is back in Run.
- R7: Halt (status 5) stops the CPU clock, the peripheral clock, the main regulator and the fast oscillator. The slow oscillator stays on only if `cfg_wdg_keep` is set. Active-halt (status 4, chosen by `cfg_ahalt`) keeps the slow oscillator on, and its main regulator follows `cfg_ahalt_mvr`. Either halt state exits on `irq_pending`, or on any `wake_in` bit after a two-flop synchroniser; a wake bit raised before clock edge 1 takes effect at edge 3.
- R8: On exit from either halt state, `clk_hsi8` becomes 1 if `cfg_fast_wake` is set and is left unchanged otherwise. A `user_clk_sel` pulse clears it to 0.
- R9: `req_lprun` in Run, outside an interrupt routine, enters Low-power-run (status 2). That state has the CPU clock on, the main regulator and fast oscillator off, and flash powered down. `req_wfe` there enters Low-power-wait (status 3, CPU clock off), which leaves only on `evt_in` and goes back to Low-power-run. Both states ignore interrupts.
- R10: `req_lprun_exit` raises `mvr_en` while `flash_pd` stays 1 until `reg_ready`. `flash_pd` then drops, and only after `flash_ready` does the state return to Run with `hsi_en` 1. Status reads 2 throughout this exit sequence.
- R11: After a wake by interrupt, `isr_return` re-enters the previous sleep if `cfg_act_level` was 1 at the clock edge two cycles before the edge that samples the return. Otherwise the core stays in Run.
- R12: `mode_status` is valid every cycle and never exceeds 5. Its codes are Run=0, Wait=1, Low-power-run=2, Low-power-wait=3, Active-halt=4, Halt=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wfi | input | 1 | CPU wait-for-interrupt request pulse |
| req_wfe | input | 1 | CPU wait-for-event request pulse |
| req_halt | input | 1 | CPU halt request pulse |
| req_lprun | input | 1 | Software request to enter low-power-run |
| req_lprun_exit | input | 1 | Software request to leave low-power-run |
| isr_return | input | 1 | Interrupt-return pulse from the CPU |
| irq_pending | input | 1 | An enabled interrupt is pending |
| evt_in | input | 1 | Event pulse |
| wake_in | input | NUM_WAKE | Asynchronous wakeup lines for halt states |
| clksw_busy | input | 1 | System clock switch in progress |
| nvm_busy | input | 1 | Flash/EEPROM write in progress |
| rtcsw_busy | input | 1 | RTC clock switch in progress |
| beep_busy | input | 1 | Beeper clock switch in progress |
| cfg_ahalt | input | 1 | Halt request targets Active-halt |
| cfg_beep_keep | input | 1 | Beeper stays enabled in Active-halt |
| cfg_fast_wake | input | 1 | Wake from halt onto internal oscillator /8 |
| cfg_wait_fpd | input | 1 | Power down flash during Wait |
| cfg_ahalt_mvr | input | 1 | Keep main regulator in Active-halt |
| cfg_wdg_keep | input | 1 | Watchdog keeps slow oscillator alive in Halt |
| cfg_act_level | input | 1 | Return to sleep after interrupt routine |
| user_clk_sel | input | 1 | Software selected its own clock source |
| reg_ready | input | 1 | Main regulator ready |
| flash_ready | input | 1 | Flash out of power-down |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| flash_pd | output | 1 | Flash power-down request |
| mvr_en | output | 1 | Main regulator enable |
| hsi_en | output | 1 | Fast oscillator enable |
| lsi_en | output | 1 | Slow oscillator enable |
| clk_hsi8 | output | 1 | System clock is internal oscillator /8 |
| gie_set | output | 1 | Global interrupt enable pulse on Wait entry |
| mode_status | output | 3 | Current mode code |

## Verification
Two functions can meet in one cycle. In a wait-for-event sleep, an event can end the sleep while an interrupt asks to run its routine and come back. The bench raises `evt_in` and `irq_pending` in the same cycle. It then checks that Run is reached, and that a later `isr_return` leaves the core in Run instead of sending it back to Wait. In the same way, a halt request is issued while an interrupt is already pending. The bench judges it on a halt state that lasts exactly one cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MS_RUN    = 3'd0,
    MS_WAIT   = 3'd1,
    MS_LPRUN  = 3'd2,
    MS_LPWAIT = 3'd3,
    MS_AHALT  = 3'd4,
    MS_HALT   = 3'd5
  } mode_code_e;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_HOLD,
    ST_WAIT,
    ST_AHALT,
    ST_HALT,
    ST_LPRUN,
    ST_LPWAIT,
    ST_XREG,
    ST_XFLASH
  } seq_state_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic fpd;
    logic mvr;
    logic hsi;
    logic lsi;
  } pwr_ctl_t;

  // Visible mode code for each internal state; transient stages report
  // the mode they belong to.
  function automatic mode_code_e status_of(seq_state_e s);
    case (s)
      ST_WAIT:                     return MS_WAIT;
      ST_LPRUN, ST_XREG, ST_XFLASH: return MS_LPRUN;
      ST_LPWAIT:                   return MS_LPWAIT;
      ST_AHALT:                    return MS_AHALT;
      ST_HALT:                     return MS_HALT;
      default:                     return MS_RUN;
    endcase
  endfunction

  // Clock, regulator and flash controls for each internal state.
  function automatic pwr_ctl_t ctl_of(seq_state_e s, logic wait_fpd,
                                      logic ahalt_mvr, logic wdg_keep);
    pwr_ctl_t c;
    c = '{cpu: 1'b1, per: 1'b1, fpd: 1'b0, mvr: 1'b1, hsi: 1'b1, lsi: 1'b1};
    case (s)
      ST_HOLD:   c.cpu = 1'b0;
      ST_WAIT:   begin c.cpu = 1'b0; c.fpd = wait_fpd; end
      ST_LPRUN:  begin c.fpd = 1'b1; c.mvr = 1'b0; c.hsi = 1'b0; end
      ST_LPWAIT: begin c.cpu = 1'b0; c.fpd = 1'b1; c.mvr = 1'b0; c.hsi = 1'b0; end
      ST_XREG:   begin c.fpd = 1'b1; c.hsi = 1'b0; end
      ST_XFLASH: c.hsi = 1'b0;
      ST_AHALT:  begin
        c.cpu = 1'b0; c.per = 1'b0; c.fpd = 1'b1; c.mvr = ahalt_mvr; c.hsi = 1'b0;
      end
      ST_HALT:   begin
        c.cpu = 1'b0; c.per = 1'b0; c.fpd = 1'b1; c.mvr = 1'b0; c.hsi = 1'b0;
        c.lsi = wdg_keep;
      end
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int NUM_WAKE = 4,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] wake_async,
  output logic                wake_any
);
  localparam int LAST = STAGES - 1;

  logic [NUM_WAKE-1:0] synced;

  for (genvar w = 0; w < NUM_WAKE; w++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else begin
        chain[0] <= wake_async[w];
        for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
    end
    assign synced[w] = chain[LAST];
  end

  assign wake_any = |synced;
endmodule

// File: rtl/lpm_lag.sv
module lpm_lag #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else begin
      stg[0] <= din;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/lpm_halt_gate.sv
module lpm_halt_gate (
  input  logic clksw_busy,
  input  logic nvm_busy,
  input  logic rtcsw_busy,
  input  logic beep_busy,
  input  logic cfg_ahalt,
  input  logic cfg_beep_keep,
  output logic busy_any
);
  logic beep_counts;
  assign beep_counts = beep_busy & cfg_ahalt & cfg_beep_keep;
  assign busy_any    = clksw_busy | nvm_busy | rtcsw_busy | beep_counts;
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm import lpm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wfi,
  input  logic       req_wfe,
  input  logic       req_halt,
  input  logic       req_lprun,
  input  logic       req_lprun_exit,
  input  logic       isr_return,
  input  logic       irq_pending,
  input  logic       evt_in,
  input  logic       wake_any,
  input  logic       busy_any,
  input  logic       act_eff,
  input  logic       cfg_ahalt,
  input  logic       cfg_fast_wake,
  input  logic       user_clk_sel,
  input  logic       reg_ready,
  input  logic       flash_ready,
  output seq_state_e state,
  output logic       clk_hsi8,
  output logic       gie_set
);
  seq_state_e nxt;
  logic wfe_q, nxt_wfe;
  logic isr_q, nxt_isr;
  logic ret_halt_q, nxt_ret_halt;
  logic ret_wfe_q, nxt_ret_wfe;
  logic hsi8_set;

  always_comb begin
    nxt          = state;
    nxt_wfe      = wfe_q;
    nxt_isr      = isr_q;
    nxt_ret_halt = ret_halt_q;
    nxt_ret_wfe  = ret_wfe_q;
    hsi8_set     = 1'b0;
    case (state)
      ST_RUN: begin
        if (req_halt) begin
          nxt = ST_HOLD; nxt_isr = 1'b0;
        end else if (req_wfe) begin
          nxt = ST_WAIT; nxt_wfe = 1'b1; nxt_isr = 1'b0;
        end else if (req_wfi) begin
          nxt = ST_WAIT; nxt_wfe = 1'b0; nxt_isr = 1'b0;
        end else if (req_lprun && !isr_q) begin
          nxt = ST_LPRUN;
        end else if (isr_return && isr_q) begin
          nxt_isr = 1'b0;
          if (ret_wfe_q || act_eff) begin
            if (ret_halt_q) nxt = ST_HOLD;
            else begin
              nxt = ST_WAIT; nxt_wfe = ret_wfe_q;
            end
          end
        end
      end
      ST_HOLD: if (!busy_any) nxt = cfg_ahalt ? ST_AHALT : ST_HALT;
      ST_WAIT: begin
        if (wfe_q && evt_in) nxt = ST_RUN;
        else if (irq_pending) begin
          nxt = ST_RUN; nxt_isr = 1'b1; nxt_ret_halt = 1'b0; nxt_ret_wfe = wfe_q;
        end
      end
      ST_AHALT, ST_HALT: begin
        if (irq_pending || wake_any) begin
          nxt = ST_RUN; nxt_isr = 1'b1; nxt_ret_halt = 1'b1; nxt_ret_wfe = 1'b0;
          hsi8_set = cfg_fast_wake;
        end
      end
      ST_LPRUN: begin
        if (req_wfe) nxt = ST_LPWAIT;
        else if (req_lprun_exit) nxt = ST_XREG;
      end
      ST_LPWAIT: if (evt_in) nxt = ST_LPRUN;
      ST_XREG:   if (reg_ready) nxt = ST_XFLASH;
      ST_XFLASH: if (flash_ready) nxt = ST_RUN;
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      wfe_q      <= 1'b0;
      isr_q      <= 1'b0;
      ret_halt_q <= 1'b0;
      ret_wfe_q  <= 1'b0;
      clk_hsi8   <= 1'b1;
      gie_set    <= 1'b0;
    end else begin
      state      <= nxt;
      wfe_q      <= nxt_wfe;
      isr_q      <= nxt_isr;
      ret_halt_q <= nxt_ret_halt;
      ret_wfe_q  <= nxt_ret_wfe;
      gie_set    <= (nxt == ST_WAIT) && (state != ST_WAIT);
      if (hsi8_set) clk_hsi8 <= 1'b1;
      else if (user_clk_sel) clk_hsi8 <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_pwr_decode.sv
module lpm_pwr_decode import lpm_pkg::*; (
  input  seq_state_e state,
  input  logic       cfg_wait_fpd,
  input  logic       cfg_ahalt_mvr,
  input  logic       cfg_wdg_keep,
  output pwr_ctl_t   ctl,
  output logic [2:0] status
);
  assign ctl    = ctl_of(state, cfg_wait_fpd, cfg_ahalt_mvr, cfg_wdg_keep);
  assign status = status_of(state);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer import lpm_pkg::*; #(
  parameter int NUM_WAKE    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_LAG     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wfi,
  input  logic                req_wfe,
  input  logic                req_halt,
  input  logic                req_lprun,
  input  logic                req_lprun_exit,
  input  logic                isr_return,
  input  logic                irq_pending,
  input  logic                evt_in,
  input  logic [NUM_WAKE-1:0] wake_in,
  input  logic                clksw_busy,
  input  logic                nvm_busy,
  input  logic                rtcsw_busy,
  input  logic                beep_busy,
  input  logic                cfg_ahalt,
  input  logic                cfg_beep_keep,
  input  logic                cfg_fast_wake,
  input  logic                cfg_wait_fpd,
  input  logic                cfg_ahalt_mvr,
  input  logic                cfg_wdg_keep,
  input  logic                cfg_act_level,
  input  logic                user_clk_sel,
  input  logic                reg_ready,
  input  logic                flash_ready,
  output logic                cpu_clk_en,
  output logic                per_clk_en,
  output logic                flash_pd,
  output logic                mvr_en,
  output logic                hsi_en,
  output logic                lsi_en,
  output logic                clk_hsi8,
  output logic                gie_set,
  output logic [2:0]          mode_status
);
  // Named internal events, visible to the bound checker.
  logic       wake_any;
  logic       busy_any;
  logic       act_eff;
  seq_state_e cur_state;
  pwr_ctl_t   ctl;

  lpm_wake_sync #(.NUM_WAKE(NUM_WAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wake_async(wake_in), .wake_any(wake_any)
  );

  lpm_lag #(.DEPTH(ACT_LAG)) u_act (
    .clk(clk), .rst_n(rst_n), .din(cfg_act_level), .dout(act_eff)
  );

  lpm_halt_gate u_gate (
    .clksw_busy(clksw_busy), .nvm_busy(nvm_busy), .rtcsw_busy(rtcsw_busy),
    .beep_busy(beep_busy), .cfg_ahalt(cfg_ahalt), .cfg_beep_keep(cfg_beep_keep),
    .busy_any(busy_any)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_wfi(req_wfi), .req_wfe(req_wfe), .req_halt(req_halt),
    .req_lprun(req_lprun), .req_lprun_exit(req_lprun_exit),
    .isr_return(isr_return), .irq_pending(irq_pending), .evt_in(evt_in),
    .wake_any(wake_any), .busy_any(busy_any), .act_eff(act_eff),
    .cfg_ahalt(cfg_ahalt), .cfg_fast_wake(cfg_fast_wake),
    .user_clk_sel(user_clk_sel), .reg_ready(reg_ready), .flash_ready(flash_ready),
    .state(cur_state), .clk_hsi8(clk_hsi8), .gie_set(gie_set)
  );

  lpm_pwr_decode u_dec (
    .state(cur_state), .cfg_wait_fpd(cfg_wait_fpd), .cfg_ahalt_mvr(cfg_ahalt_mvr),
    .cfg_wdg_keep(cfg_wdg_keep), .ctl(ctl), .status(mode_status)
  );

  assign cpu_clk_en = ctl.cpu;
  assign per_clk_en = ctl.per;
  assign flash_pd   = ctl.fpd;
  assign mvr_en     = ctl.mvr;
  assign hsi_en     = ctl.hsi;
  assign lsi_en     = ctl.lsi;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       flash_pd,
  input logic       mvr_en,
  input logic       evt_in,
  input logic       irq_pending,
  input logic       gie_set,
  input logic [2:0] mode_status,
  input logic       busy_any,
  input logic       wake_any
);
  // R2: Wait stops only the CPU clock
  assert_wait_cpu_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status == 3'd1 |-> !cpu_clk_en && per_clk_en && mvr_en);

  // R2: interrupt-enable pulse appears only while in Wait
  assert_gie_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set |-> mode_status == 3'd1);

  // R5: hold stage persists while the gate reports busy
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd0 && !cpu_clk_en && busy_any) |=> mode_status == 3'd0 && !cpu_clk_en);

  // R7: halt persists with no wake source
  assert_halt_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd5 && !irq_pending && !wake_any) |=> mode_status == 3'd5);

  // R9: low-power-wait leaves only on an event
  assert_lpwait_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd3 && !evt_in) |=> mode_status == 3'd3);

  // R9: low-power-wait keeps regulator off and flash powered down
  assert_lpwait_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status == 3'd3 |-> !mvr_en && flash_pd);

  // R10: flash leaves power-down only after the regulator was already on
  assert_exit_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flash_pd) && mode_status == 3'd2) |-> mvr_en && $past(mvr_en));

  // R12: status code range
  assert_status_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status <= 3'd5);
endmodule

bind lpm_sequencer lpm_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .flash_pd(flash_pd), .mvr_en(mvr_en), .evt_in(evt_in), .irq_pending(irq_pending),
  .gie_set(gie_set), .mode_status(mode_status), .busy_any(busy_any), .wake_any(wake_any)
);

// File: tb/lpm_sequencer_tb_top.sv
module lpm_sequencer_tb_top;
  localparam int NW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_wfi = 0, req_wfe = 0, req_halt = 0, req_lprun = 0, req_lprun_exit = 0;
  logic isr_return = 0, irq_pending = 0, evt_in = 0;
  logic [NW-1:0] wake_in = '0;
  logic clksw_busy = 0, nvm_busy = 0, rtcsw_busy = 0, beep_busy = 0;
  logic cfg_ahalt = 0, cfg_beep_keep = 0, cfg_fast_wake = 0, cfg_wait_fpd = 0;
  logic cfg_ahalt_mvr = 0, cfg_wdg_keep = 0, cfg_act_level = 0, user_clk_sel = 0;
  logic reg_ready = 0, flash_ready = 0;
  logic cpu_clk_en, per_clk_en, flash_pd, mvr_en, hsi_en, lsi_en, clk_hsi8, gie_set;
  logic [2:0] mode_status;

  lpm_sequencer #(.NUM_WAKE(NW)) dut_i (.*);

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: modes as small integers.
  // 0 run 1 wait 2 lprun 3 lpwait 4 ahalt 5 halt 6 hold 7 reg-step 8 flash-step
  int m_st;
  bit m_wfe, m_ctx, m_from_halt, m_from_wfe, m_hsi8, m_gie;
  bit m_w1, m_w2, m_a1, m_a2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_wfe = 0; m_ctx = 0; m_from_halt = 0; m_from_wfe = 0;
      m_hsi8 = 1; m_gie = 0; m_w1 = 0; m_w2 = 0; m_a1 = 0; m_a2 = 0;
    end else begin
      int ns;
      bit busy, back;
      ns = m_st;
      busy = clksw_busy || nvm_busy || rtcsw_busy || (beep_busy && cfg_ahalt && cfg_beep_keep);
      if (m_st == 0) begin
        if (req_halt) begin ns = 6; m_ctx = 0; end
        else if (req_wfe || req_wfi) begin ns = 1; m_wfe = req_wfe; m_ctx = 0; end
        else if (req_lprun && !m_ctx) ns = 2;
        else if (isr_return && m_ctx) begin
          m_ctx = 0;
          back = m_from_wfe || m_a2;
          if (back) begin
            if (m_from_halt) ns = 6;
            else begin ns = 1; m_wfe = m_from_wfe; end
          end
        end
      end else if (m_st == 6) begin
        if (!busy) ns = cfg_ahalt ? 4 : 5;
      end else if (m_st == 1) begin
        if (m_wfe && evt_in) ns = 0;
        else if (irq_pending) begin ns = 0; m_ctx = 1; m_from_halt = 0; m_from_wfe = m_wfe; end
      end else if (m_st == 4 || m_st == 5) begin
        if (irq_pending || m_w2) begin
          ns = 0; m_ctx = 1; m_from_halt = 1; m_from_wfe = 0;
          if (cfg_fast_wake) m_hsi8 = 1;
          else if (user_clk_sel) m_hsi8 = 0;
        end else if (user_clk_sel) m_hsi8 = 0;
      end else if (m_st == 2) begin
        if (req_wfe) ns = 3; else if (req_lprun_exit) ns = 7;
      end else if (m_st == 3) begin
        if (evt_in) ns = 2;
      end else if (m_st == 7) begin
        if (reg_ready) ns = 8;
      end else if (m_st == 8) begin
        if (flash_ready) ns = 0;
      end
      if (!(m_st == 4 || m_st == 5) && user_clk_sel) m_hsi8 = 0;
      m_gie = (ns == 1) && (m_st != 1);
      m_st = ns;
      m_w2 = m_w1; m_w1 = |wake_in;
      m_a2 = m_a1; m_a1 = cfg_act_level;
    end
  end

  function automatic int exp_status(int s);
    case (s)
      6: return 0;
      7, 8: return 2;
      default: return s;
    endcase
  endfunction

  // Per-clock comparison of every output against the reference.
  bit compare_on = 0;
  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      int e_cpu, e_per, e_fpd, e_mvr, e_hsi, e_lsi;
      e_cpu = (m_st == 0 || m_st == 2 || m_st == 7 || m_st == 8);
      e_per = !(m_st == 4 || m_st == 5);
      e_fpd = (m_st == 1) ? cfg_wait_fpd : (m_st >= 2 && m_st <= 5) || m_st == 7;
      e_mvr = (m_st == 2 || m_st == 3 || m_st == 5) ? 0 : (m_st == 4) ? cfg_ahalt_mvr : 1;
      e_hsi = (m_st == 0 || m_st == 1 || m_st == 6);
      e_lsi = (m_st == 5) ? cfg_wdg_keep : 1;
      chk("R12 mode_status", mode_status, exp_status(m_st));
      chk("R2 cpu_clk_en", cpu_clk_en, e_cpu);
      chk("R7 per_clk_en", per_clk_en, e_per);
      chk("R10 flash_pd", flash_pd, e_fpd);
      chk("R10 mvr_en", mvr_en, e_mvr);
      chk("R9 hsi_en", hsi_en, e_hsi);
      chk("R7 lsi_en", lsi_en, e_lsi);
      chk("R8 clk_hsi8", clk_hsi8, m_hsi8);
      chk("R2 gie_set", gie_set, m_gie);
    end
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse one request line for a cycle; return at the negedge after the edge.
  task automatic pulse(int which);
    case (which)
      0: req_wfi = 1; 1: req_wfe = 1; 2: req_halt = 1; 3: req_lprun = 1;
      4: req_lprun_exit = 1; 5: isr_return = 1; 6: evt_in = 1; 7: user_clk_sel = 1;
      default: irq_pending = 1;
    endcase
    @(negedge clk);
    req_wfi = 0; req_wfe = 0; req_halt = 0; req_lprun = 0; req_lprun_exit = 0;
    isr_return = 0; evt_in = 0; user_clk_sel = 0;
    if (which == 8) irq_pending = 0;
  endtask

  localparam int P_WFI = 0, P_WFE = 1, P_HALT = 2, P_LPR = 3, P_LPX = 4;
  localparam int P_RET = 5, P_EVT = 6, P_USR = 7, P_IRQ = 8;

  initial begin
    step(3);
    rst_n = 1;
    compare_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", mode_status, 0);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 hsi8", clk_hsi8, 1);
    chk("R1 flash_pd", flash_pd, 0);
    chk("R1 mvr", mvr_en, 1);

    // R2/R3 wait for interrupt
    cfg_wait_fpd = 1;
    pulse(P_WFI);
    chk("R2 status", mode_status, 1);
    chk("R2 cpu off", cpu_clk_en, 0);
    chk("R2 gie pulse", gie_set, 1);
    chk("R2 flash_pd", flash_pd, 1);
    step(3);
    chk("R2 gie single", gie_set, 0);
    chk("R3 still asleep", mode_status, 1);
    pulse(P_IRQ);
    chk("R3 woke", mode_status, 0);
    pulse(P_RET);
    chk("R11 no act level", mode_status, 0);
    cfg_wait_fpd = 0;

    // R4 wait for event
    pulse(P_WFE);
    chk("R4 asleep", mode_status, 1);
    pulse(P_EVT);
    chk("R4 event wake", mode_status, 0);
    pulse(P_RET);
    chk("R4 return without ctx", mode_status, 0);
    pulse(P_WFE);
    pulse(P_IRQ);
    chk("R4 irq wake", mode_status, 0);
    step(2);
    pulse(P_RET);
    chk("R4 back to wfe", mode_status, 1);
    evt_in = 1; irq_pending = 1;
    @(negedge clk);
    evt_in = 0; irq_pending = 0;
    chk("R4 both same cycle", mode_status, 0);
    pulse(P_RET);
    chk("R4 event won", mode_status, 0);

    // R5 busy hold, R7 halt and wake lines
    nvm_busy = 1;
    pulse(P_HALT);
    chk("R5 hold", mode_status, 0);
    chk("R5 cpu stopped", cpu_clk_en, 0);
    step(4);
    chk("R5 still hold", mode_status, 0);
    nvm_busy = 0;
    @(negedge clk);
    chk("R5 halt after busy", mode_status, 5);
    chk("R7 per off", per_clk_en, 0);
    chk("R7 lsi off", lsi_en, 0);
    wake_in[2] = 1;
    @(negedge clk);
    chk("R7 sync stage 1", mode_status, 5);
    @(negedge clk);
    chk("R7 sync stage 2", mode_status, 5);
    @(negedge clk);
    chk("R7 woke", mode_status, 0);
    wake_in = '0;
    step(3);
    pulse(P_RET);

    // R8 wake clock selection
    pulse(P_USR);
    chk("R8 user clock", clk_hsi8, 0);
    pulse(P_HALT);
    @(negedge clk);
    chk("R8 in halt", mode_status, 5);
    pulse(P_IRQ);
    chk("R8 kept clock", clk_hsi8, 0);
    pulse(P_RET);
    cfg_fast_wake = 1;
    pulse(P_HALT);
    @(negedge clk);
    pulse(P_IRQ);
    chk("R8 fast wake", clk_hsi8, 1);
    pulse(P_RET);
    cfg_fast_wake = 0;

    // R6 halt with pending interrupt
    irq_pending = 1;
    pulse(P_HALT);
    @(negedge clk);
    chk("R6 one halt cycle", mode_status, 5);
    @(negedge clk);
    chk("R6 back to run", mode_status, 0);
    irq_pending = 0;
    pulse(P_RET);

    // R5 beeper flag gating, R7 active-halt
    beep_busy = 1; cfg_beep_keep = 1; cfg_ahalt_mvr = 1;
    pulse(P_HALT);
    @(negedge clk);
    chk("R5 beeper ignored for halt", mode_status, 5);
    pulse(P_IRQ);
    pulse(P_RET);
    cfg_ahalt = 1;
    pulse(P_HALT);
    step(3);
    chk("R5 beeper holds active-halt", mode_status, 0);
    beep_busy = 0;
    @(negedge clk);
    chk("R7 active-halt", mode_status, 4);
    chk("R7 lsi on", lsi_en, 1);
    chk("R7 mvr by cfg", mvr_en, 1);
    pulse(P_IRQ);
    pulse(P_RET);
    cfg_ahalt = 0; cfg_beep_keep = 0; cfg_ahalt_mvr = 0;

    // R11 activation level
    cfg_act_level = 1;
    step(2);
    pulse(P_WFI);
    pulse(P_IRQ);
    chk("R11 in isr", mode_status, 0);
    step(1);
    pulse(P_RET);
    chk("R11 back to sleep", mode_status, 1);
    pulse(P_IRQ);
    cfg_act_level = 0;
    @(negedge clk);
    pulse(P_RET);
    chk("R11 cleared too late", mode_status, 1);
    pulse(P_IRQ);
    step(2);
    pulse(P_RET);
    chk("R11 main loop resumes", mode_status, 0);

    // R9 low-power run and wait, R10 exit handshake
    pulse(P_LPR);
    chk("R9 lprun", mode_status, 2);
    chk("R9 mvr off", mvr_en, 0);
    chk("R9 flash down", flash_pd, 1);
    irq_pending = 1;
    step(2);
    chk("R9 irq ignored", mode_status, 2);
    irq_pending = 0;
    pulse(P_WFE);
    chk("R12 lpwait code", mode_status, 3);
    irq_pending = 1;
    step(3);
    chk("R9 lpwait ignores irq", mode_status, 3);
    irq_pending = 0;
    pulse(P_EVT);
    chk("R9 back to lprun", mode_status, 2);
    pulse(P_LPX);
    chk("R10 regulator on", mvr_en, 1);
    chk("R10 flash still down", flash_pd, 1);
    step(3);
    chk("R10 waits regulator", flash_pd, 1);
    reg_ready = 1;
    @(negedge clk);
    chk("R10 flash released", flash_pd, 0);
    chk("R10 fast osc still off", hsi_en, 0);
    chk("R10 status during exit", mode_status, 2);
    flash_ready = 1;
    @(negedge clk);
    chk("R10 run", mode_status, 0);
    chk("R10 fast osc", hsi_en, 1);
    reg_ready = 0; flash_ready = 0;
    step(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule